// File: doc/BRIEF.md
# Thirteen-level phase-disposition PWM generator

This block produces the gate drive for a single-phase inverter with thirteen output levels. Inside, a phase accumulator and a folded sine-shaped function make a low-frequency reference. A modulation-index input scales that reference. One shared up/down counter makes a triangular carrier. Twelve copies of the carrier are stacked in bands of one carrier unit each: six bands above zero and six below. All copies share the same amplitude, frequency and phase.

Each band compares the reference with its own copy of the carrier and drives its own pair of complementary switches. A band above zero drives an upper pair (switch "on" / switch "off"). A band below zero drives a lower pair. Each pair gets a programmable dead time whenever its comparison flips. The block also outputs a signed level number that equals the staircase step the power stage would produce, so a checker or a test can follow the waveform without modelling the power circuit.

Top module: `pd_pwm13`

## Requirements
- R1: The registered `level` output equals the number of upper bands whose carrier lies below the reference, minus the number of lower bands whose carrier lies above it. The value is taken from the state one clock earlier and always stays within -6 to +6.
- R2: Upper band k (k = 0..5) compares the reference with carrier `k*H + c`, where c is the counter value. If the reference is strictly greater, the pair's first switch (`gate_up_on[k]`) is selected. Otherwise its second switch (`gate_up_off[k]`) is selected.
- R3: Lower band k (k = 0..5) compares the reference with carrier `c - (k+1)*H`. If the reference is strictly smaller, the third switch (`gate_dn_on[k]`) is selected. Otherwise the fourth switch (`gate_dn_off[k]`) is selected.
- R4: The two gates of a pair are never high together, and outside dead time exactly one of them is high.
- R5: When a pair's registered comparison changes, both gates of that pair stay low in that cycle and for `dead_cycles` further cycles. After that they follow the comparison.
- R6: The carrier counter runs 0,1,…,H,H-1,…,1,0,… with H = CLK_HZ/(2*CARRIER_HZ). All twelve bands use this one counter, so the carriers stay in phase.
- R7: The phase advances by floor(REF_HZ·2^32/CLK_HZ) every clock. The reference is computed from the phase as follows:
  - Take p = phase[30:16].
  - shape = p(32768-p)/8192.
  - Scale by the Q1.15 index: shape·mi/32768.
  - Scale to the peak: multiply by floor(PEAK_TENTHS·H/10) and divide by 32768.
  - Negate when phase[31] is set.
  - All divisions truncate.
- R8: Over one reference period, an index of 1.0 (32768) reaches all 13 levels. An index of 0.7 (22938) reaches 11 levels, with a top of +5. An index of 0.5 (16384) reaches 7 levels, with a top of +3.
- R9: A synchronous reset clears the phase, the counter and `level`. All gates then stay low until the first carrier period has ended, which is the 2H-th cycle after reset.
- R10: An index of zero keeps `level` at 0. Once armed, it keeps only the second and fourth switches of every pair high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_index | input | 16 | Modulation index, unsigned Q1.15 |
| dead_cycles | input | DT_W | Extra dead-time cycles after a comparison flip |
| gate_up_on | output | 6 | First switch of each upper band |
| gate_up_off | output | 6 | Second switch of each upper band |
| gate_dn_on | output | 6 | Third switch of each lower band |
| gate_dn_off | output | 6 | Fourth switch of each lower band |
| level | output | 4 | Signed staircase step, -6 to +6 |

## Verification
The properties assume that `dead_cycles` is written only while reset is held. They also assume that the reset is active from time zero, so the counter-step and phase-step checks never see an unreset state. The bench changes `dead_cycles` only inside its reset task and holds `rst` high from the first instant. It drives `mod_index` on falling edges, and its per-cycle model uses the index value that was present at each rising edge. Index values above 1.0 are allowed; the stacked comparisons saturate the level at ±6.

// File: rtl/pd_pwm13_pkg.sv
package pd_pwm13_pkg;

  // Half-wave shape from the 15 phase bits below the sign bit: 4p(1-p) in Q15.
  function automatic logic [16:0] arch_shape(input logic [14:0] p);
    logic [31:0] prod;
    prod = {17'd0, p} * (32'd32768 - {17'd0, p});
    return prod[29:13];
  endfunction

  // Signed reference in counter units: shape, times index, times peak.
  function automatic logic signed [31:0] scale_ref(input logic [31:0] ph,
                                                  input logic [15:0] mi,
                                                  input logic [31:0] peak);
    logic [63:0] mag;
    logic [63:0] amp;
    mag = ({47'd0, arch_shape(ph[30:16])} * {48'd0, mi}) >> 15;
    amp = (mag * {32'd0, peak}) >> 15;
    return ph[31] ? -$signed(amp[31:0]) : $signed(amp[31:0]);
  endfunction

endpackage

// File: rtl/pd_pwm13_ref.sv
module pd_pwm13_ref #(
  parameter int CLK_HZ = 100_000_000,
  parameter int REF_HZ = 50,
  parameter int PEAK   = 14750
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [15:0]        mi,
  output logic signed [31:0] ref_val
);
  import pd_pwm13_pkg::*;

  localparam logic [63:0] INC64 = (64'(REF_HZ) << 32) / 64'(CLK_HZ);
  localparam logic [31:0] INC   = INC64[31:0];

  logic [31:0] phase;
  logic        live;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      live  <= 1'b0;
    end else begin
      phase <= phase + INC;
      live  <= 1'b1;
    end
  end

  assign ref_val = scale_ref(phase, mi, 32'(PEAK));

  p_phase_step_r7: assert property (@(posedge clk) disable iff (rst)
    live |-> phase == $past(phase) + INC);

endmodule

// File: rtl/pd_pwm13_carrier.sv
module pd_pwm13_carrier #(
  parameter int HALF = 2500,
  localparam int CW  = $clog2(HALF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output logic          armed
);
  logic up;
  logic live;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      up    <= 1'b1;
      armed <= 1'b0;
      live  <= 1'b0;
    end else begin
      live <= 1'b1;
      if (up) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(HALF - 1)) up <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          up    <= 1'b1;
          armed <= 1'b1;
        end
      end
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(HALF));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    live |-> (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pd_pwm13_dead.sv
module pd_pwm13_dead #(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            arm,
  input  logic            raw,
  input  logic [DT_W-1:0] dead,
  output logic            on,
  output logic            off
);
  logic            raw_d;
  logic [DT_W-1:0] dtc;
  logic            flip;
  logic            open;

  assign flip = raw ^ raw_d;
  assign open = arm && !flip && (dtc == '0);
  assign on   = open && raw;
  assign off  = open && !raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_d <= 1'b0;
      dtc   <= '0;
    end else begin
      raw_d <= raw;
      if (flip)            dtc <= dead;
      else if (dtc != '0)  dtc <= dtc - 1'b1;
    end
  end

  p_pair_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(on && off));

  p_gap_on_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(on) |-> !$past(off));

  p_gap_off_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(off) |-> !$past(on));

  p_unarmed_low_r9: assert property (@(posedge clk) disable iff (rst)
    !arm |-> !on && !off);

endmodule

// File: rtl/pd_pwm13.sv
module pd_pwm13 #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int CARRIER_HZ  = 20_000,
  parameter int REF_HZ      = 50,
  parameter int PEAK_TENTHS = 59,
  parameter int NBANDS      = 6,
  parameter int DT_W        = 4,
  localparam int HALF       = CLK_HZ / (2 * CARRIER_HZ),
  localparam int PEAK       = PEAK_TENTHS * HALF / 10,
  localparam int CW         = $clog2(HALF + 1),
  localparam int LW         = $clog2(NBANDS + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [15:0]          mod_index,
  input  logic [DT_W-1:0]      dead_cycles,
  output logic [NBANDS-1:0]    gate_up_on,
  output logic [NBANDS-1:0]    gate_up_off,
  output logic [NBANDS-1:0]    gate_dn_on,
  output logic [NBANDS-1:0]    gate_dn_off,
  output logic signed [LW-1:0] level
);
  logic signed [31:0] ref_val;
  logic [CW-1:0]      cnt;
  logic               armed;
  logic signed [31:0] car_val;
  logic [NBANDS-1:0]  cmp_up, cmp_dn;
  logic [NBANDS-1:0]  raw_up, raw_dn;
  logic signed [LW-1:0] lvl_next;

  pd_pwm13_ref #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ), .PEAK(PEAK)) u_ref (
    .clk(clk), .rst(rst), .mi(mod_index), .ref_val(ref_val));

  pd_pwm13_carrier #(.HALF(HALF)) u_car (
    .clk(clk), .rst(rst), .cnt(cnt), .armed(armed));

  assign car_val = $signed({{(32 - CW){1'b0}}, cnt});

  for (genvar k = 0; k < NBANDS; k++) begin : g_band
    localparam logic signed [31:0] OFF_UP = 32'(k * HALF);
    localparam logic signed [31:0] OFF_DN = 32'((k + 1) * HALF);
    assign cmp_up[k] = ref_val > (car_val + OFF_UP);
    assign cmp_dn[k] = ref_val < (car_val - OFF_DN);

    pd_pwm13_dead #(.DT_W(DT_W)) u_dt_up (
      .clk(clk), .rst(rst), .arm(armed), .raw(raw_up[k]), .dead(dead_cycles),
      .on(gate_up_on[k]), .off(gate_up_off[k]));

    pd_pwm13_dead #(.DT_W(DT_W)) u_dt_dn (
      .clk(clk), .rst(rst), .arm(armed), .raw(raw_dn[k]), .dead(dead_cycles),
      .on(gate_dn_on[k]), .off(gate_dn_off[k]));

    if (k > 0) begin : g_stack
      p_up_stack_r2: assert property (@(posedge clk) disable iff (rst)
        raw_up[k] |-> raw_up[k-1]);
      p_dn_stack_r3: assert property (@(posedge clk) disable iff (rst)
        raw_dn[k] |-> raw_dn[k-1]);
    end
  end

  always_comb begin
    lvl_next = '0;
    for (int i = 0; i < NBANDS; i++) begin
      lvl_next = lvl_next + $signed({{(LW - 1){1'b0}}, cmp_up[i]});
      lvl_next = lvl_next - $signed({{(LW - 1){1'b0}}, cmp_dn[i]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_up <= '0;
      raw_dn <= '0;
      level  <= '0;
    end else begin
      raw_up <= cmp_up;
      raw_dn <= cmp_dn;
      level  <= lvl_next;
    end
  end

  p_level_range_r1: assert property (@(posedge clk) disable iff (rst)
    (level <= LW'(NBANDS)) && (level >= -LW'(NBANDS)));

  p_no_both_sides_r1: assert property (@(posedge clk) disable iff (rst)
    !(raw_up[0] && raw_dn[0]));

endmodule

// File: tb/pd_pwm13_bench.sv
module pd_pwm13_bench;
  localparam int  CLK_HZ = 1_000_000;
  localparam int  CAR_HZ = 20_000;
  localparam int  REF_HZ = 50;
  localparam int  H      = CLK_HZ / (2 * CAR_HZ);
  localparam int  PK     = 59 * H / 10;
  localparam longint INC = (longint'(REF_HZ) << 32) / CLK_HZ;
  localparam int  RPER   = 20100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] mi = 16'd0;
  logic [3:0]  dead_v = 4'd3;
  logic [5:0]  up_on, up_off, dn_on, dn_off;
  logic signed [3:0] level;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pd_pwm13 #(.CLK_HZ(CLK_HZ), .CARRIER_HZ(CAR_HZ), .REF_HZ(REF_HZ)) u_pd_pwm13 (
    .clk(clk), .rst(rst), .mod_index(mi), .dead_cycles(dead_v),
    .gate_up_on(up_on), .gate_up_off(up_off), .gate_dn_on(dn_on),
    .gate_dn_off(dn_off), .level(level));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R7: reference restated with divisions on the cycle index.
  function automatic int ref_of(longint n, longint m);
    longint ph, p, sh, mg, am;
    ph = (n * INC) % (longint'(1) << 32);
    p  = (ph >> 16) % 32768;
    sh = (p * (32768 - p)) / 8192;
    mg = (sh * m) / 32768;
    am = (mg * PK) / 32768;
    return (ph >= (longint'(1) << 31)) ? -int'(am) : int'(am);
  endfunction

  // R6: triangle value at cycle index n.
  function automatic int tri_of(longint n);
    longint m;
    m = n % (2 * H);
    return int'((m <= H) ? m : 2 * H - m);
  endfunction

  // Per-cycle model: state index, expected comparisons, level and flip runs.
  longint n = 0;
  logic [5:0] e_up = '0, e_dn = '0;
  int e_lvl = 0;
  int run_up[6], run_dn[6];
  bit mon = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      n = 0; e_up = '0; e_dn = '0; e_lvl = 0;
      for (int k = 0; k < 6; k++) begin run_up[k] = 1000; run_dn[k] = 1000; end
    end else begin
      int r, c, l;
      logic [5:0] nu, nd;
      r = ref_of(n, longint'(mi));
      c = tri_of(n);
      l = 0;
      for (int k = 0; k < 6; k++) begin
        nu[k] = r > k * H + c;          // R2
        nd[k] = r < c - (k + 1) * H;    // R3
        l += int'(nu[k]) - int'(nd[k]);
        run_up[k] = (nu[k] != e_up[k]) ? 0 : ((run_up[k] < 1000) ? run_up[k] + 1 : 1000);
        run_dn[k] = (nd[k] != e_dn[k]) ? 0 : ((run_dn[k] < 1000) ? run_dn[k] + 1 : 1000);
      end
      e_up = nu; e_dn = nd; e_lvl = l;
      n = n + 1;
    end
  end

  always @(negedge clk) begin
    if (mon) begin
      logic [23:0] eg;
      bit arm;
      arm = (n >= 2 * H);
      for (int k = 0; k < 6; k++) begin
        bit ou, od;
        ou = arm && (run_up[k] >= int'(dead_v) + 1);
        od = arm && (run_dn[k] >= int'(dead_v) + 1);
        eg[k]      = ou && e_up[k];
        eg[6 + k]  = ou && !e_up[k];
        eg[12 + k] = od && e_dn[k];
        eg[18 + k] = od && !e_dn[k];
      end
      check(int'(level) == e_lvl, "R1 level", longint'(level), e_lvl);
      check({dn_off, dn_on, up_off, up_on} == eg, "R2 R3 R4 R5 R9 gates",
            {dn_off, dn_on, up_off, up_on}, eg);
    end
  end

  task automatic t_reset(input logic [3:0] dt);
    @(negedge clk);
    rst = 1'b1; dead_v = dt; mi = 16'd32768;
    repeat (4) @(negedge clk);
    check(level == 4'sd0, "R9 level cleared", longint'(level), 0);
    check({up_on, up_off, dn_on, dn_off} == '0, "R9 gates low in reset",
          {up_on, up_off, dn_on, dn_off}, 0);
    rst = 1'b0; mon = 1'b1;
    repeat (2 * H - 1) @(negedge clk);
    check({up_on, up_off, dn_on, dn_off} == '0, "R9 gates low before first period end",
          {up_on, up_off, dn_on, dn_off}, 0);
    repeat (dt + 2) @(negedge clk);
    check(|{up_on, up_off, dn_on, dn_off}, "R9 gates active after arming", 0, 1);
  endtask

  task automatic t_levels(input logic [15:0] m, input int nlev, input int top);
    logic [12:0] seen = '0;
    int hi = -7, lo = 7;
    @(negedge clk); mi = m;
    repeat (RPER) begin
      @(negedge clk);
      seen[int'(level) + 6] = 1'b1;
      if (int'(level) > hi) hi = int'(level);
      if (int'(level) < lo) lo = int'(level);
    end
    check($countones(seen) == nlev, "R8 distinct levels", $countones(seen), nlev);
    check(hi == top, "R8 top level", hi, top);
    check(lo == -top, "R8 bottom level", lo, -top);
    check(hi <= 6 && lo >= -6, "R1 level range", hi, 6);
  endtask

  task automatic t_zero();
    bit lvl_ok = 1'b1, gate_ok = 1'b1;
    @(negedge clk); mi = 16'd0;
    repeat (2 * H + 20) @(negedge clk);
    repeat (3000) begin
      @(negedge clk);
      if (level != 4'sd0) lvl_ok = 1'b0;
      if (up_on != 6'd0 || dn_on != 6'd0 || up_off != 6'h3f || dn_off != 6'h3f) gate_ok = 1'b0;
    end
    check(lvl_ok, "R10 level stays zero", lvl_ok, 1);
    check(gate_ok, "R10 only second and fourth switches", gate_ok, 1);
  endtask

  initial begin
    t_reset(4'd3);
    t_levels(16'd32768, 13, 6);
    t_levels(16'd22938, 11, 5);
    t_levels(16'd16384, 7, 3);
    t_zero();
    t_reset(4'd0);
    t_levels(16'd65535, 13, 6);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(150_000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule